// File: doc/BRIEF.md
# BCD Clock and Calendar Counter

This block keeps wall-clock time and a calendar as packed BCD fields and advances them once per second. The second comes from a binary prescaler that counts rising edges of a 32.768 kHz oscillator waveform sampled in the system clock domain. The same prescaler feeds a frequency output that carries either the oscillator itself or a delayed 1 Hz square wave, with a separate drive-enable signal for an external three-state pad.

Software or neighbouring logic sets the time by presenting every field on a parallel bus with a one-cycle load strobe. A hold input stops the seconds from advancing, and a prescaler-clear input restarts the second so that the next tick arrives roughly one full second after it is released. A one-cycle pulse marks every seconds increment, so a reader taking a snapshot can tell whether the fields moved under it.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 00..59 and hours 00..23 in BCD (low nibble never above 9); 59 seconds rolls to 00 and carries into minutes, 59 minutes carries into hours, hour 23 rolls to 00 and starts a new day.
- R2: The weekday field counts 1..7 and steps once per new day, going from 7 back to 1, regardless of the date.
- R3: Day runs from 01 up to the last day of the month and then returns to 01 with the month stepping; months 04, 06, 09 and 11 end on day 30, months 01, 03, 05, 07, 08, 10 and 12 end on day 31.
- R4: February ends on day 29 when the BCD year, read as a number 0..99, is a multiple of 4 (year 00 included), and on day 28 otherwise.
- R5: Month 12 rolls to 01 and steps the year; year 99 rolls to 00.
- R6: A one-second tick occurs once every 2^DIV_BITS rising edges of the oscillator input.
- R7: While the prescaler-clear input is high no tick occurs; after it falls, the next tick comes no sooner than 2^DIV_BITS - 2^KEEP_BITS and no later than 2^DIV_BITS oscillator edges later.
- R8: With the load strobe high, every field takes the bus value on the next clock edge, and a tick in that cycle is discarded.
- R9: While the hold input is high the seconds field does not advance and no update pulse appears.
- R10: The update pulse is high for exactly one cycle, the same cycle the new seconds value first appears, and only when the seconds changed by counting.
- R11: With the select input low the frequency output follows the sampled oscillator level; with it high the output is a 1 Hz square wave that rises 2^(KEEP_BITS+2) oscillator edges after each tick and stays high for half a second. The drive-enable output follows the output-enable input.
- R12: After reset the fields read 00:00:00, weekday 1, day 01, month 01, year 00, and the update pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | 32.768 kHz oscillator level, sampled by clk |
| presc_clr | input | 1 | Holds the prescaler second stages cleared |
| carry_hold | input | 1 | Blocks ticks from advancing the seconds |
| ld_stb | input | 1 | Parallel load strobe |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_wday | input | 3 | Weekday to load, 1..7 |
| ld_day | input | 8 | BCD day of month to load |
| ld_mon | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| fsel | input | 1 | Output select: 0 oscillator, 1 one-hertz wave |
| fout_en | input | 1 | Output enable for the frequency pad |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| wday_o | output | 3 | Weekday 1..7 |
| day_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| sec_pulse | output | 1 | One-cycle flag on each seconds increment |
| fout | output | 1 | Frequency output data |
| fout_oe | output | 1 | Pad drive enable; pad is high impedance when low |

## Verification
The bench builds the block with DIV_BITS = 7 and KEEP_BITS = 2 and feeds an oscillator wave with a two-cycle period, so one second lasts 256 system clocks and the 1 Hz output rises 32 clocks after each tick. That brings every calendar boundary within a few hundred cycles: each vector loads the instant just before a midnight, month end, leap or non-leap February or century wrap and watches one tick resolve it. The short second also makes the prescaler-clear window, the hold behaviour and the phase of the delayed 1 Hz wave measurable to the exact clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Increment a two-digit packed BCD value (no range check).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year (BCD 00..99) is a leap year when its value is a multiple of 4.
  function automatic logic is_leap(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  // Last day of the month, in BCD.
  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS  = 15,
  parameter int KEEP_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  input  logic presc_clr,
  input  logic fsel,
  output logic tick_1s,
  output logic fout_wave
);
  localparam logic [DIV_BITS-1:0] ALL_ONES = '1;
  localparam logic [DIV_BITS-1:0] SHIFT    = DIV_BITS'(2 ** (KEEP_BITS + 2));

  logic                osc_q, osc_p;
  logic                osc_edge;
  logic [DIV_BITS-1:0] div_cnt;
  logic [DIV_BITS-1:0] div_nxt;
  logic [DIV_BITS-1:0] shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      osc_p <= 1'b0;
    end else begin
      osc_q <= osc_in;
      osc_p <= osc_q;
    end
  end

  assign osc_edge = osc_q & ~osc_p;

  always_comb begin
    div_nxt = div_cnt + DIV_BITS'(1);
    if (presc_clr) div_nxt[DIV_BITS-1:KEEP_BITS] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (osc_edge) div_cnt <= div_nxt;
    else if (presc_clr) div_cnt[DIV_BITS-1:KEEP_BITS] <= '0;
  end

  assign tick_1s = osc_edge & (div_cnt == ALL_ONES) & ~presc_clr;

  // Internal second is high in the first half; output lags it by SHIFT edges.
  assign shifted   = div_cnt - SHIFT;
  assign fout_wave = fsel ? ~shifted[DIV_BITS-1] : osc_q;

  AST_CLR_HOLDS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> (div_cnt[DIV_BITS-1:KEEP_BITS] == '0)) else $error("clear");  // R7
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       ld,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       sec_pulse,
  output logic       day_step
);
  logic sec_end, min_end, hour_end, adv;

  assign sec_end  = (sec  == 8'h59);
  assign min_end  = (min  == 8'h59);
  assign hour_end = (hour == 8'h23);
  assign adv      = step & ~ld;
  assign day_step = adv & sec_end & min_end & hour_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= adv;
      if (ld) begin
        sec <= ld_sec; min <= ld_min; hour <= ld_hour;
      end else if (step) begin
        sec <= sec_end ? 8'h00 : bcd_inc(sec);
        if (sec_end) min <= min_end ? 8'h00 : bcd_inc(min);
        if (sec_end && min_end) hour <= hour_end ? 8'h00 : bcd_inc(hour);
      end
    end
  end

  AST_SEC_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9) && (sec <= 8'h59)) else $error("sec range");  // R1
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    day_step |=> (hour == 8'h00) && (min == 8'h00)) else $error("hour wrap");  // R1
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !step) |=> !sec_pulse) else $error("pulse width");  // R10
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       ld,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [2:0] wday,
  output logic [7:0] day,
  output logic [7:0] mon,
  output logic [7:0] year
);
  logic [7:0] last;
  logic       day_end, mon_end;

  assign last    = month_end(mon, year);
  assign day_end = (day == last);
  assign mon_end = (mon == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday <= 3'd1; day <= 8'h01; mon <= 8'h01; year <= 8'h00;
    end else if (ld) begin
      wday <= ld_wday; day <= ld_day; mon <= ld_mon; year <= ld_year;
    end else if (step) begin
      wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
      day  <= day_end ? 8'h01 : bcd_inc(day);
      if (day_end) mon <= mon_end ? 8'h01 : bcd_inc(mon);
      if (day_end && mon_end) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && wday == 3'd7) |=> (wday == 3'd1)) else $error("wday");  // R2
  AST_FEB_LEAP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && mon == 8'h02 && day == 8'h28 && year == 8'h24) |=> (day == 8'h29)) else $error("leap");  // R4
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && day_end && mon_end) |=> (mon == 8'h01) && (day == 8'h01)) else $error("year");  // R5
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int DIV_BITS  = 15,
  parameter int KEEP_BITS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_in,
  input  logic       presc_clr,
  input  logic       carry_hold,
  input  logic       ld_stb,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic       fsel,
  input  logic       fout_en,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [2:0] wday_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       sec_pulse,
  output logic       fout,
  output logic       fout_oe
);
  logic tick_1s, sec_step, day_step;

  rtc_prescaler #(.DIV_BITS(DIV_BITS), .KEEP_BITS(KEEP_BITS)) u_presc (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .presc_clr(presc_clr),
    .fsel(fsel), .tick_1s(tick_1s), .fout_wave(fout)
  );

  assign sec_step = tick_1s & ~carry_hold;
  assign fout_oe  = fout_en;

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .step(sec_step), .ld(ld_stb),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .sec(sec_o), .min(min_o), .hour(hour_o),
    .sec_pulse(sec_pulse), .day_step(day_step)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .step(day_step), .ld(ld_stb),
    .ld_wday(ld_wday), .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
    .wday(wday_o), .day(day_o), .mon(mon_o), .year(year_o)
  );

  AST_HOLD_KEEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_hold && !ld_stb) |=> $stable(sec_o) && !sec_pulse) else $error("hold");  // R9
  AST_CLR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> !sec_pulse) else $error("clr pulse");  // R7
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> (sec_o == $past(ld_sec)) && (day_o == $past(ld_day)) && !sec_pulse) else $error("load");  // R8
  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (sec_o != $past(sec_o))) else $error("pulse");  // R10
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int CLK_PERIOD = 10;
  localparam int SEC_CLKS   = 256;   // 2^7 osc edges x 2 clocks

  typedef struct packed {
    logic [7:0] s, m, h;
    logic [2:0] w;
    logic [7:0] d, mo, y;
  } cal_t;
  typedef struct packed { cal_t pre; cal_t post; } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{'{8'h59,8'h59,8'h23,3'd7,8'h28,8'h02,8'h23}, '{8'h00,8'h00,8'h00,3'd1,8'h01,8'h03,8'h23}},
    '{'{8'h59,8'h59,8'h23,3'd3,8'h28,8'h02,8'h24}, '{8'h00,8'h00,8'h00,3'd4,8'h29,8'h02,8'h24}},
    '{'{8'h59,8'h59,8'h23,3'd4,8'h29,8'h02,8'h24}, '{8'h00,8'h00,8'h00,3'd5,8'h01,8'h03,8'h24}},
    '{'{8'h59,8'h59,8'h23,3'd2,8'h30,8'h04,8'h05}, '{8'h00,8'h00,8'h00,3'd3,8'h01,8'h05,8'h05}},
    '{'{8'h59,8'h59,8'h23,3'd2,8'h30,8'h01,8'h05}, '{8'h00,8'h00,8'h00,3'd3,8'h31,8'h01,8'h05}},
    '{'{8'h59,8'h59,8'h23,3'd5,8'h31,8'h12,8'h99}, '{8'h00,8'h00,8'h00,3'd6,8'h01,8'h01,8'h00}},
    '{'{8'h09,8'h34,8'h12,3'd1,8'h15,8'h06,8'h10}, '{8'h10,8'h34,8'h12,3'd1,8'h15,8'h06,8'h10}},
    '{'{8'h59,8'h59,8'h09,3'd1,8'h15,8'h06,8'h10}, '{8'h00,8'h00,8'h10,3'd1,8'h15,8'h06,8'h10}},
    '{'{8'h59,8'h59,8'h23,3'd6,8'h30,8'h11,8'h12}, '{8'h00,8'h00,8'h00,3'd7,8'h01,8'h12,8'h12}},
    '{'{8'h59,8'h59,8'h23,3'd1,8'h28,8'h02,8'h00}, '{8'h00,8'h00,8'h00,3'd2,8'h29,8'h02,8'h00}},
    '{'{8'h59,8'h59,8'h23,3'd7,8'h31,8'h07,8'h31}, '{8'h00,8'h00,8'h00,3'd1,8'h01,8'h08,8'h31}}
  };

  logic clk = 1'b0, rst_n = 1'b0, osc_in = 1'b0;
  logic presc_clr = 1'b0, carry_hold = 1'b0, ld_stb = 1'b0, fsel = 1'b0, fout_en = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_day = '0, ld_mon = '0, ld_year = '0;
  logic [2:0] ld_wday = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
  logic [2:0] wday_o;
  logic sec_pulse, fout, fout_oe;
  int checks = 0, fails = 0, cyc = 0;

  rtc_calendar_core #(.DIV_BITS(7), .KEEP_BITS(2)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .presc_clr(presc_clr),
    .carry_hold(carry_hold), .ld_stb(ld_stb), .ld_sec(ld_sec), .ld_min(ld_min),
    .ld_hour(ld_hour), .ld_wday(ld_wday), .ld_day(ld_day), .ld_mon(ld_mon),
    .ld_year(ld_year), .fsel(fsel), .fout_en(fout_en), .sec_o(sec_o),
    .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .day_o(day_o),
    .mon_o(mon_o), .year_o(year_o), .sec_pulse(sec_pulse), .fout(fout),
    .fout_oe(fout_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) osc_in <= ~osc_in;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic cal_t now_cal();
    return '{sec_o, min_o, hour_o, wday_o, day_o, mon_o, year_o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Returns cycles waited until sec_pulse seen at a negedge.
  task automatic wait_pulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_pulse && n < 2000);
  endtask

  task automatic do_load(input cal_t c);
    ld_sec = c.s; ld_min = c.m; ld_hour = c.h; ld_wday = c.w;
    ld_day = c.d; ld_mon = c.mo; ld_year = c.y; ld_stb = 1'b1;
    @(negedge clk); ld_stb = 1'b0;
  endtask

  initial begin
    int n;
    int seen;
    logic prev;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(now_cal() == cal_t'({8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00}) && !sec_pulse,
          "R12 reset state", 64'(now_cal()), 64'(cal_t'({8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00})));
    rst_n = 1'b1;

    // R6: tick spacing
    wait_pulse(n);
    wait_pulse(n);
    check(n == SEC_CLKS, "R6 tick spacing", 64'(n), 64'(SEC_CLKS));
    @(negedge clk);
    check(!sec_pulse, "R10 pulse width", 64'(sec_pulse), 64'(0));

    // Table of calendar vectors: R1 R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      wait_pulse(n);
      do_load(VECS[i].pre);
      check(now_cal() == VECS[i].pre, $sformatf("R8 load vector %0d", i),
            64'(now_cal()), 64'(VECS[i].pre));
      wait_pulse(n);
      check(now_cal() == VECS[i].post, $sformatf("R1 R2 R3 R4 R5 vector %0d", i),
            64'(now_cal()), 64'(VECS[i].post));
    end

    // R8: load in the tick cycle wins; pulse suppressed
    wait_pulse(n);
    repeat (SEC_CLKS - 2) @(negedge clk);
    ld_sec = 8'h30; ld_min = 8'h00; ld_hour = 8'h05; ld_wday = 3'd2;
    ld_day = 8'h10; ld_mon = 8'h10; ld_year = 8'h10; ld_stb = 1'b1;
    @(negedge clk); ld_stb = 1'b0;
    check(sec_o == 8'h30 && !sec_pulse, "R8 load beats tick", 64'(sec_o), 64'h30);

    // R9: hold stops seconds and pulses
    carry_hold = 1'b1;
    seen = 0;
    for (int k = 0; k < 3 * SEC_CLKS; k++) begin
      @(negedge clk);
      if (sec_pulse) seen++;
    end
    check(seen == 0 && sec_o == 8'h30, "R9 hold", 64'(sec_o), 64'h30);
    carry_hold = 1'b0;
    wait_pulse(n);
    check(sec_o == 8'h31, "R9 resume after hold", 64'(sec_o), 64'h31);

    // R7: prescaler clear
    repeat (50) @(negedge clk);
    presc_clr = 1'b1;
    seen = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (sec_pulse) seen++;
    end
    check(seen == 0, "R7 no tick while cleared", 64'(seen), 64'(0));
    presc_clr = 1'b0;
    wait_pulse(n);
    check(n >= 2 * (128 - 4) - 4 && n <= SEC_CLKS + 4, "R7 first tick after clear",
          64'(n), 64'(SEC_CLKS));
    check(sec_o == 8'h32, "R7 seconds after clear", 64'(sec_o), 64'h32);

    // R11: 1 Hz phase
    fsel = 1'b1; fout_en = 1'b1;
    @(negedge clk);
    check(fout_oe == 1'b1, "R11 oe follows enable", 64'(fout_oe), 64'(1));
    wait_pulse(n);
    repeat (10) @(negedge clk);
    check(fout == 1'b0, "R11 1Hz low before delay", 64'(fout), 64'(0));
    repeat (50) @(negedge clk);
    check(fout == 1'b1, "R11 1Hz high after delay", 64'(fout), 64'(1));
    repeat (140) @(negedge clk);
    check(fout == 1'b0, "R11 1Hz low second half", 64'(fout), 64'(0));

    // R11: oscillator pass-through toggles every clock
    fsel = 1'b0; fout_en = 1'b0;
    @(negedge clk);
    check(fout_oe == 1'b0, "R11 oe off", 64'(fout_oe), 64'(0));
    prev = fout;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (fout != prev) seen++;
      prev = fout;
    end
    check(seen == 8, "R11 oscillator pass-through", 64'(seen), 64'(8));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule